// File: doc/BRIEF.md
# Q-Channel Subcode Capture and Serial Readout

This block gathers the Q channel of the disc subcode, which arrives one bit per subcode frame with a strobe. It runs a CRC over each 96-bit field as the bits arrive. A block-sync strobe marks where each field ends. When a field passes the CRC, its 80 data bits are copied into a readout shift register. During the copy the bits inside each byte are reversed, so the host receives each byte LSB first while the byte order stays the same. The CRC-good flag is set at the same time.

A host reads the block over two wires. It applies 80 pulses on its serial clock and takes one bit from the serial output on each pulse. While no readout is running, the serial output shows the CRC-good flag, so the same wire also tells the host that a fresh block is waiting.

A retriggerable lockout timer runs on the system clock. It guards the readout register: a validated block that arrives while the host is clocking, or too soon after the last clock pulse, is dropped. The host therefore never reads a mixture of two blocks.

The read-state machine has three states:
- `ST_SHOW`: the output shows the flag.
- `ST_LOW`: the host clock is low and a data bit is presented.
- `ST_HIGH`: between pulses, with the next bit presented.

Its transitions are:
- SHOW→LOW on a falling edge.
- LOW→HIGH on a rising edge that is not the 80th.
- LOW→SHOW on the 80th rising edge.
- HIGH→LOW on a falling edge.
- Any state→SHOW on a register load.

Top module: `subq_reader`

## Requirements
- R1: After reset, `crcf` is 0, `sqso` is 0 and the reader is in status mode.
- R2: On a `scor` strobe, the field counts as good only if exactly 96 `q_stb` bits came since the previous `scor`. The CRC uses polynomial 0x1021 with an all-zero preset. It runs over the first 80 bits in arrival order, each new bit entering at the top of the register. It must equal the bitwise inverse of the last 16 bits, taken first-arrived as MSB. Any other field loads nothing and leaves `crcf` at 0.
- R3: Number readout positions 0 to 79 and received data bits 0 to 79 (index 0 arrives first). Readout position 8b+k carries received bit 8b+7−k.
- R4: The first `sqck` falling edge puts readout position 0 on `sqso`. Each rising edge advances one position. After the 80th rising edge, the reader returns to status mode.
- R5: Every synchronized `sqck` edge, rising or falling, clears `crcf`.
- R6: In status mode `sqso` equals `crcf`. A load sets `crcf` to 1.
- R7: A CRC pass is dropped, and not held for later, in two cases: while `sqck` is low, or within `LOCK_CYCLES` clocks after its last rising edge. The readout register keeps its contents.
- R8: A load that happens after a paused, unfinished readout returns the reader to status mode. A later 80-pulse read then returns the new block from position 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| q_bit | input | 1 | Q subcode bit for the current frame |
| q_stb | input | 1 | One-cycle strobe qualifying `q_bit` |
| scor | input | 1 | One-cycle block-sync strobe ending a field |
| sqck | input | 1 | Host serial clock, asynchronous, idles high |
| sqso | output | 1 | Serial data during readout, CRC flag otherwise |
| crcf | output | 1 | CRC-good flag for the block in the readout register |

## Verification
The hardest case to reach is a valid block that arrives during a readout, because the read has to stall partway through to leave room for it. The bench stops in the middle of a read and holds the host clock low. It then delivers a complete, correct field and its sync strobe, and resumes the read, which must still return the old block. A second case loads the 96 bits during the final low phase and sends the sync strobe a few cycles after the last rising edge, inside the retrigger window. Both cases need the bench to place field delivery and host pulses on its own schedule, and the bench sweeps several data patterns through that schedule.

// File: rtl/subq_pkg.sv
package subq_pkg;

    localparam int Q_DATA_BITS  = 80;
    localparam int Q_CHECK_BITS = 16;
    localparam logic [15:0] Q_CRC_POLY = 16'h1021;

    typedef enum logic [1:0] {
        ST_SHOW = 2'd0,
        ST_LOW  = 2'd1,
        ST_HIGH = 2'd2
    } rd_state_t;

    function automatic logic [15:0] crc_step(input logic [15:0] cur, input logic din);
        logic fb;
        fb = cur[15] ^ din;
        return {cur[14:0], 1'b0} ^ (fb ? Q_CRC_POLY : 16'h0000);
    endfunction

endpackage

// File: rtl/subq_collect.sv
module subq_collect
    import subq_pkg::*;
#(
    parameter int DATA_BITS  = Q_DATA_BITS,
    parameter int CHECK_BITS = Q_CHECK_BITS
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 q_bit,
    input  logic                 q_stb,
    input  logic                 scor,
    output logic [DATA_BITS-1:0] field_data,
    output logic                 crc_pass
);

    localparam int FIELD_BITS = DATA_BITS + CHECK_BITS;
    localparam int CW         = $clog2(FIELD_BITS + 2);
    localparam logic [CW-1:0] FIELD_V = CW'(FIELD_BITS);
    localparam logic [CW-1:0] DATA_V  = CW'(DATA_BITS);
    localparam logic [CW-1:0] OVER_V  = CW'(FIELD_BITS + 1);

    logic [CW-1:0]         bit_cnt;
    logic [15:0]           crc_q;
    logic [CHECK_BITS-1:0] chk_q;
    logic [DATA_BITS-1:0]  data_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt <= '0;
            crc_q   <= '0;
            chk_q   <= '0;
            data_q  <= '0;
        end else if (scor) begin
            if (q_stb) begin
                bit_cnt <= CW'(1);
                crc_q   <= crc_step(16'h0000, q_bit);
                data_q  <= {data_q[DATA_BITS-2:0], q_bit};
            end else begin
                bit_cnt <= '0;
                crc_q   <= '0;
            end
        end else if (q_stb) begin
            if (bit_cnt < DATA_V) begin
                data_q <= {data_q[DATA_BITS-2:0], q_bit};
                crc_q  <= crc_step(crc_q, q_bit);
            end else if (bit_cnt < FIELD_V) begin
                chk_q <= {chk_q[CHECK_BITS-2:0], q_bit};
            end
            if (bit_cnt != OVER_V) begin
                bit_cnt <= bit_cnt + CW'(1);
            end
        end
    end

    assign field_data = data_q;
    assign crc_pass   = scor && (bit_cnt == FIELD_V) && (crc_q == ~chk_q);

endmodule

// File: rtl/subq_lockout.sv
module subq_lockout #(
    parameter int LOCK_CYCLES = 67000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sqck_in,
    output logic sqck_rise,
    output logic sqck_fall,
    output logic lock_active
);

    localparam int TW = $clog2(LOCK_CYCLES + 1);
    localparam logic [TW-1:0] LOCK_V = TW'(LOCK_CYCLES);

    logic [2:0]    sync_q;
    logic [TW-1:0] hold_cnt;
    logic          lvl;

    assign lvl = sync_q[1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= 3'b111;
        end else begin
            sync_q <= {sync_q[1:0], sqck_in};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold_cnt <= LOCK_V;
        end else if (!lvl) begin
            hold_cnt <= '0;
        end else if (hold_cnt != LOCK_V) begin
            hold_cnt <= hold_cnt + TW'(1);
        end
    end

    assign sqck_rise   = sync_q[1] & ~sync_q[2];
    assign sqck_fall   = ~sync_q[1] & sync_q[2];
    assign lock_active = ~lvl | (hold_cnt != LOCK_V);

endmodule

// File: rtl/subq_readout.sv
module subq_readout
    import subq_pkg::*;
#(
    parameter int DATA_BITS = Q_DATA_BITS
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         load,
    input  logic [DATA_BITS-1:0]         load_data,
    input  logic                         sqck_rise,
    input  logic                         sqck_fall,
    output logic                         sqso,
    output logic                         crcf,
    output rd_state_t                    state,
    output logic [DATA_BITS-1:0]         sr,
    output logic [$clog2(DATA_BITS)-1:0] bcnt
);

    localparam int BW = $clog2(DATA_BITS);
    localparam logic [BW-1:0] LAST_V = BW'(DATA_BITS - 1);

    rd_state_t st_q, st_nxt;
    logic      last_bit;

    assign last_bit = (bcnt == LAST_V);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= ST_SHOW;
        end else begin
            st_q <= st_nxt;
        end
    end

    always_comb begin
        st_nxt = st_q;
        unique case (st_q)
            ST_SHOW: if (sqck_fall) st_nxt = ST_LOW;
            ST_LOW:  if (sqck_rise) st_nxt = last_bit ? ST_SHOW : ST_HIGH;
            ST_HIGH: if (sqck_fall) st_nxt = ST_LOW;
            default: st_nxt = ST_SHOW;
        endcase
        if (load) begin
            st_nxt = ST_SHOW;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sr   <= '0;
            bcnt <= '0;
            crcf <= 1'b0;
        end else if (load) begin
            sr   <= load_data;
            bcnt <= '0;
            crcf <= 1'b1;
        end else begin
            if (st_q == ST_LOW && sqck_rise) begin
                sr   <= {1'b0, sr[DATA_BITS-1:1]};
                bcnt <= last_bit ? '0 : bcnt + BW'(1);
            end
            if (sqck_rise || sqck_fall) begin
                crcf <= 1'b0;
            end
        end
    end

    always_comb begin
        unique case (st_q)
            ST_SHOW: sqso = crcf;
            ST_LOW,
            ST_HIGH: sqso = sr[0];
            default: sqso = crcf;
        endcase
    end

    assign state = st_q;

endmodule

// File: rtl/subq_reader.sv
module subq_reader
    import subq_pkg::*;
#(
    parameter int DATA_BITS   = Q_DATA_BITS,
    parameter int CHECK_BITS  = Q_CHECK_BITS,
    parameter int LOCK_CYCLES = 67000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic q_bit,
    input  logic q_stb,
    input  logic scor,
    input  logic sqck,
    output logic sqso,
    output logic crcf
);

    localparam int NBYTES = DATA_BITS / 8;

    logic [DATA_BITS-1:0]         rx_data;
    logic [DATA_BITS-1:0]         rev_data;
    logic                         crc_pass;
    logic                         sqck_rise, sqck_fall, lock_active;
    logic                         load;
    rd_state_t                    rd_state;
    logic [DATA_BITS-1:0]         sr;
    logic [$clog2(DATA_BITS)-1:0] bcnt;

    subq_collect #(
        .DATA_BITS (DATA_BITS),
        .CHECK_BITS(CHECK_BITS)
    ) u_collect (
        .clk       (clk),
        .rst_n     (rst_n),
        .q_bit     (q_bit),
        .q_stb     (q_stb),
        .scor      (scor),
        .field_data(rx_data),
        .crc_pass  (crc_pass)
    );

    subq_lockout #(
        .LOCK_CYCLES(LOCK_CYCLES)
    ) u_lockout (
        .clk        (clk),
        .rst_n      (rst_n),
        .sqck_in    (sqck),
        .sqck_rise  (sqck_rise),
        .sqck_fall  (sqck_fall),
        .lock_active(lock_active)
    );

    // rx_data holds the first-arrived bit at its top; readout slot 8b+k takes arrival 8b+7-k
    for (genvar b = 0; b < NBYTES; b++) begin : g_byte
        for (genvar k = 0; k < 8; k++) begin : g_bit
            assign rev_data[b*8 + k] = rx_data[DATA_BITS - 1 - (b*8 + 7 - k)];
        end
    end

    assign load = crc_pass & ~lock_active;

    subq_readout #(
        .DATA_BITS(DATA_BITS)
    ) u_readout (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .load_data(rev_data),
        .sqck_rise(sqck_rise),
        .sqck_fall(sqck_fall),
        .sqso     (sqso),
        .crcf     (crcf),
        .state    (rd_state),
        .sr       (sr),
        .bcnt     (bcnt)
    );

endmodule

// File: rtl/subq_reader_chk.sv
module subq_reader_chk
    import subq_pkg::*;
#(
    parameter int DATA_BITS = Q_DATA_BITS
) (
    input logic                         clk,
    input logic                         rst_n,
    input logic                         scor,
    input logic                         crc_pass,
    input logic                         sqck_rise,
    input logic                         sqck_fall,
    input logic                         lock_active,
    input logic                         crcf,
    input rd_state_t                    rd_state,
    input logic [DATA_BITS-1:0]         sr,
    input logic [$clog2(DATA_BITS)-1:0] bcnt
);

    // R2: a pass verdict only exists on a sync strobe
    a_r2_pass_on_sync: assert property (@(posedge clk) disable iff (!rst_n)
        crc_pass |-> scor);

    // R5: any host clock edge leaves the flag low
    a_r5_edge_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (sqck_rise || sqck_fall) |=> !crcf);

    // R7: while locked, only a shift may touch the register
    a_r7_locked_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (lock_active && !sqck_rise) |=> $stable(sr));

    // R6: the flag only rises in status mode
    a_r6_flag_in_show: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(crcf) |-> (rd_state == ST_SHOW));

    // R4: the position counter stays inside the block
    a_r4_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        bcnt < ($clog2(DATA_BITS))'(DATA_BITS));

    // R4: status mode always starts from position 0
    a_r4_show_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_state == ST_SHOW) |-> (bcnt == '0));

endmodule

bind subq_reader subq_reader_chk #(.DATA_BITS(DATA_BITS)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .scor       (scor),
    .crc_pass   (crc_pass),
    .sqck_rise  (sqck_rise),
    .sqck_fall  (sqck_fall),
    .lock_active(lock_active),
    .crcf       (crcf),
    .rd_state   (rd_state),
    .sr         (sr),
    .bcnt       (bcnt)
);

// File: tb/subq_reader_tb.sv
module subq_reader_tb;

    localparam int LOCK = 40;
    localparam int H    = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic q_bit = 1'b0, q_stb = 1'b0, scor = 1'b0, sqck = 1'b1;
    logic sqso, crcf;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    logic fdat [80];
    logic fchk [16];
    logic expv [80];
    logic rd   [80];

    always #2.5 clk = ~clk;

    subq_reader #(.LOCK_CYCLES(LOCK)) u_dut (
        .clk  (clk),
        .rst_n(rst_n),
        .q_bit(q_bit),
        .q_stb(q_stb),
        .scor (scor),
        .sqck (sqck),
        .sqso (sqso),
        .crcf (crcf)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic make_frame(input int p);
        logic [15:0] c;
        logic [7:0]  v;
        logic        fb;
        for (int b = 0; b < 10; b++) begin
            if (p == 0)      v = 8'h00;
            else if (p == 1) v = 8'hFF;
            else             v = 8'((b * 37 + p * 101 + b * p * 13) & 255);
            for (int k = 0; k < 8; k++) fdat[b*8 + k] = v[7-k];
        end
        c = 16'h0000;
        for (int j = 0; j < 80; j++) begin
            fb = c[15] ^ fdat[j];
            c  = {c[14:0], 1'b0} ^ (fb ? 16'h1021 : 16'h0000);
        end
        c = ~c;
        for (int j = 0; j < 16; j++) fchk[j] = c[15-j];
    endtask

    task automatic set_exp();
        for (int i = 0; i < 80; i++) expv[i] = fdat[(i/8)*8 + 7 - (i%8)];
    endtask

    task automatic send_bits(input int n, input bit corrupt);
        for (int j = 0; j < n; j++) begin
            @(negedge clk);
            q_stb = 1'b1;
            q_bit = (j < 80) ? fdat[j] : fchk[(j - 80) % 16];
            if (corrupt && j == 5) q_bit = ~q_bit;
        end
        @(negedge clk);
        q_stb = 1'b0;
    endtask

    task automatic pulse_scor();
        @(negedge clk); scor = 1'b1;
        @(negedge clk); scor = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    // mode 1: full field + sync while low at pulse inj; mode 2: field in last low, sync right after
    task automatic host_read(input int n, input int inj, input int mode);
        for (int p = 0; p < n; p++) begin
            @(negedge clk); sqck = 1'b0;
            repeat (H) @(negedge clk);
            if (mode == 1 && p == inj) begin
                send_bits(96, 1'b0);
                pulse_scor();
            end
            if (mode == 2 && p == n - 1) send_bits(96, 1'b0);
            rd[p] = sqso;
            if (p == 0) chk(crcf == 1'b0, "R5 flag after first edge", int'(crcf), 0);
            sqck = 1'b1;
            repeat (H) @(negedge clk);
        end
        if (mode == 2) begin
            @(negedge clk); scor = 1'b1;
            @(negedge clk); scor = 1'b0;
        end
    endtask

    task automatic compare_read(input string req);
        for (int i = 0; i < 80; i++) chk(rd[i] === expv[i], req, int'(rd[i]), int'(expv[i]));
    endtask

    task automatic idle_check(input string req);
        repeat (LOCK + 10) @(negedge clk);
        chk(crcf == 1'b0, req, int'(crcf), 0);
        chk(sqso == 1'b0, req, int'(sqso), 0);
    endtask

    task automatic good_load(input int p, input string req);
        make_frame(p);
        send_bits(96, 1'b0);
        pulse_scor();
        chk(crcf == 1'b1, req, int'(crcf), 1);
        chk(sqso == 1'b1, req, int'(sqso), 1);
        set_exp();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(crcf == 1'b0, "R1 crcf", int'(crcf), 0);
        chk(sqso == 1'b0, "R1 sqso", int'(sqso), 0);
        rst_n = 1'b1;
        repeat (LOCK + 5) @(negedge clk);
        chk(crcf == 1'b0, "R1 crcf idle", int'(crcf), 0);

        // R2 R6 R3 R4 over a sweep of patterns
        for (int p = 0; p < 6; p++) begin
            good_load(p, "R2 R6 good field");
            host_read(80, 0, 0);
            compare_read("R3 R4 readout bit");
            idle_check("R4 status after 80");
        end

        // R2 corrupted field
        make_frame(7);
        send_bits(96, 1'b1);
        pulse_scor();
        chk(crcf == 1'b0, "R2 bad crc", int'(crcf), 0);
        // R2 short and long fields
        send_bits(95, 1'b0);
        pulse_scor();
        chk(crcf == 1'b0, "R2 short field", int'(crcf), 0);
        send_bits(97, 1'b0);
        pulse_scor();
        chk(crcf == 1'b0, "R2 long field", int'(crcf), 0);

        // R7 pass while clock held low mid-read
        good_load(8, "R2 load A");
        make_frame(9);
        host_read(80, 40, 1);
        compare_read("R7 old block kept");
        idle_check("R7 dropped not queued");

        // R7 pass inside retrigger window after last rise
        good_load(10, "R2 load A2");
        make_frame(11);
        host_read(80, 0, 2);
        compare_read("R7 old block kept window");
        idle_check("R7 window drop");

        // fresh load after idle still works
        good_load(12, "R7 load after idle");
        host_read(80, 0, 0);
        compare_read("R3 after lockout");

        // R8 load after an abandoned partial read
        good_load(13, "R8 first block");
        host_read(10, 0, 0);
        repeat (LOCK + 20) @(negedge clk);
        good_load(14, "R8 reload status");
        host_read(80, 0, 0);
        compare_read("R8 new block from start");
        idle_check("R8 status after read");

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule